// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block returns a two-wire bus that may have been left stuck to the idle state, before the main bus controller is used. One request starts a fixed sequence. First the block waits for any transfer still in progress, but only up to a bounded number of polls. Next it holds the controller in soft reset and takes direct open-drain control of the clock and data lines. It toggles the clock until both lines read high, or until an attempt limit is reached. It then forces a START condition and a STOP condition, releases the soft reset, and reports completion.

All waits are counted in system clock cycles. Every delay is a microsecond figure multiplied by the `CLK_PER_US` parameter. The line levels pass through a synchronizer before the block looks at them. Every pin is a plain control or status signal. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure to manage.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `ctl_srst`, `done` and `stuck` are all 0 (0 means the line is released and the controller is out of reset).
- R2: After a request, `ctl_srst` stays 0 as long as `xfer_pending` reads 1 and fewer than `POLL_LIMIT` polls have been made. Polls are spaced `GAP_US` apart. Once the limit is reached, recovery goes ahead even if `xfer_pending` is still 1.
- R3: `ctl_srst` is 1 whenever either line is driven. It falls exactly `HOLD_US*CLK_PER_US` cycles before `done` rises.
- R4: Direct control opens with both lines released for one half period. If both lines then read high, no clock pulse is issued.
- R5: Each recovery pulse holds `scl_oe` at 1 for exactly `HALF_US*CLK_PER_US` cycles, then releases the clock for the same length of time. Pulsing stops at the first check that finds both lines high.
- R6: At most `PULSE_LIMIT` pulses are issued per recovery. If the lines are still not both high after the last pulse, `stuck` becomes 1.
- R7: The START condition drives `sda_oe` to 1 only while `scl_oe` is 0, for exactly `HOLD_US*CLK_PER_US` cycles. `sda_oe` then returns to 0, which forms the STOP.
- R8: `done` is a pulse one cycle wide at the end of each recovery. `stuck` keeps its value until the next accepted request clears it.
- R9: A `start_req` that arrives while a recovery is running is ignored. It causes no second `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Starts a recovery when the block is idle |
| xfer_pending | input | 1 | 1 while the main controller has a transfer in progress |
| scl_in | input | 1 | Sensed clock line level |
| sda_in | input | 1 | Sensed data line level |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| ctl_srst | output | 1 | Soft reset to the main controller |
| done | output | 1 | One-cycle end-of-recovery pulse |
| stuck | output | 1 | Lines were still not both high after the last allowed pulse |

## Verification
Each output is decoded directly from the state register. A `start_req` driven before an edge therefore becomes visible one cycle later. Every timed phase then lasts exactly its parameter product in cycles: half period, hold time or poll gap.

Line levels reach the decision point after `SYNC_STAGES` cycles. The bench's bus model releases the data line on the falling edge of `scl_oe`, which leaves the synchronizer a full half period to settle before the next check.

The bench samples on the falling clock edge. It measures each pulse, the START/STOP hold and the gap from soft-reset release to `done` as exact cycle counts. The two poll cases are checked against a window derived from the poll gap and the poll limit.

// File: rtl/i2cu_pkg.sv
package i2cu_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POLL,
    ST_GAP,
    ST_SETTLE,
    ST_CHECK,
    ST_LOW,
    ST_HIGH,
    ST_START,
    ST_STOP,
    ST_UNRST,
    ST_FIN
  } rec_state_e;
endpackage

// File: rtl/i2cu_sync.sv
module i2cu_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '1;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cu_timer.sv
module i2cu_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] len,
  output logic         hit
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clear) cnt <= '0;
    else cnt <= cnt + W'(1);
  end

  assign hit = (cnt == len - W'(1));
endmodule

// File: rtl/i2cu_count.sv
module i2cu_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else if (clear) value <= '0;
    else if (inc) value <= value + W'(1);
  end
endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick
  import i2cu_pkg::*;
#(
  parameter int CLK_PER_US  = 50,
  parameter int HALF_US     = 100,
  parameter int HOLD_US     = 1000,
  parameter int GAP_US      = 500,
  parameter int POLL_LIMIT  = 100,
  parameter int PULSE_LIMIT = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic xfer_pending,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_oe,
  output logic sda_oe,
  output logic ctl_srst,
  output logic done,
  output logic stuck
);
  localparam int HALF_CYC = HALF_US * CLK_PER_US;
  localparam int HOLD_CYC = HOLD_US * CLK_PER_US;
  localparam int GAP_CYC  = GAP_US * CLK_PER_US;
  localparam int MAX_CYC  = (HOLD_CYC > GAP_CYC) ?
                            ((HOLD_CYC > HALF_CYC) ? HOLD_CYC : HALF_CYC) :
                            ((GAP_CYC > HALF_CYC) ? GAP_CYC : HALF_CYC);
  localparam int TW = $clog2(MAX_CYC + 1) + 1;
  localparam int PW = $clog2(POLL_LIMIT + 1) + 1;
  localparam int AW = $clog2(PULSE_LIMIT + 1) + 1;

  rec_state_e state_q, state_d;
  logic [1:0]    lines_s;
  logic          lines_ok;
  logic [TW-1:0] tmr_len;
  logic          tmr_hit, tmr_clear;
  logic [PW-1:0] poll_cnt;
  logic [AW-1:0] att_cnt;
  logic          poll_inc, att_inc, run_clear;
  logic          stuck_q;

  i2cu_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(lines_s)
  );
  assign lines_ok = &lines_s;

  i2cu_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .len(tmr_len), .hit(tmr_hit)
  );

  i2cu_count #(.W(PW)) u_polls (
    .clk(clk), .rst_n(rst_n), .clear(run_clear), .inc(poll_inc), .value(poll_cnt)
  );

  i2cu_count #(.W(AW)) u_attempts (
    .clk(clk), .rst_n(rst_n), .clear(run_clear), .inc(att_inc), .value(att_cnt)
  );

  always_comb begin
    case (state_q)
      ST_GAP:                       tmr_len = TW'(GAP_CYC);
      ST_SETTLE, ST_LOW, ST_HIGH:   tmr_len = TW'(HALF_CYC);
      ST_START, ST_STOP, ST_UNRST:  tmr_len = TW'(HOLD_CYC);
      default:                      tmr_len = TW'(1);
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_req) state_d = ST_POLL;
      ST_POLL:   if (!xfer_pending || poll_cnt == PW'(POLL_LIMIT)) state_d = ST_SETTLE;
                 else state_d = ST_GAP;
      ST_GAP:    if (tmr_hit) state_d = ST_POLL;
      ST_SETTLE: if (tmr_hit) state_d = ST_CHECK;
      ST_CHECK:  if (lines_ok || att_cnt == AW'(PULSE_LIMIT)) state_d = ST_START;
                 else state_d = ST_LOW;
      ST_LOW:    if (tmr_hit) state_d = ST_HIGH;
      ST_HIGH:   if (tmr_hit) state_d = ST_CHECK;
      ST_START:  if (tmr_hit) state_d = ST_STOP;
      ST_STOP:   if (tmr_hit) state_d = ST_UNRST;
      ST_UNRST:  if (tmr_hit) state_d = ST_FIN;
      ST_FIN:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign tmr_clear = (state_d != state_q);
  assign run_clear = (state_q == ST_IDLE);
  assign poll_inc  = (state_q == ST_POLL) && (state_d == ST_GAP);
  assign att_inc   = (state_q == ST_CHECK) && (state_d == ST_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stuck_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_req)
        stuck_q <= 1'b0;
      else if (state_q == ST_CHECK && !lines_ok && att_cnt == AW'(PULSE_LIMIT))
        stuck_q <= 1'b1;
    end
  end

  assign scl_oe   = (state_q == ST_LOW);
  assign sda_oe   = (state_q == ST_START);
  assign ctl_srst = (state_q == ST_SETTLE) || (state_q == ST_CHECK) ||
                    (state_q == ST_LOW)    || (state_q == ST_HIGH)  ||
                    (state_q == ST_START)  || (state_q == ST_STOP);
  assign done     = (state_q == ST_FIN);
  assign stuck    = stuck_q;
endmodule

// File: rtl/i2cu_chk.sv
module i2cu_chk #(
  parameter int PULSE_LIMIT = 10
) (
  input logic clk,
  input logic rst_n,
  input logic start_req,
  input logic scl_oe,
  input logic sda_oe,
  input logic ctl_srst,
  input logic done,
  input logic stuck
);
  localparam int CW = $clog2(PULSE_LIMIT + 2) + 1;
  logic          scl_q;
  logic [CW-1:0] pulse_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      scl_q <= scl_oe;
      if (done) pulse_cnt <= '0;
      else if (scl_oe && !scl_q) pulse_cnt <= pulse_cnt + CW'(1);
    end
  end

  // R3
  line_ctl_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe || sda_oe) |-> ctl_srst);
  // R3
  reset_off_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ctl_srst);
  // R7
  start_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> !scl_oe);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  pulse_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= CW'(PULSE_LIMIT));
  // R6
  stuck_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stuck) |-> pulse_cnt == CW'(PULSE_LIMIT));
  // R8
  stuck_cleared_by_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stuck) |-> $past(start_req));
endmodule

bind i2c_bus_unstick i2cu_chk #(.PULSE_LIMIT(PULSE_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .ctl_srst(ctl_srst), .done(done), .stuck(stuck)
);

// File: tb/i2c_bus_unstick_test.sv
module i2c_bus_unstick_test;
  localparam int CPU    = 1;
  localparam int HALF   = 4;
  localparam int HOLD   = 12;
  localparam int GAP    = 3;
  localparam int PLIM   = 5;
  localparam int ALIM   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic xfer_pending = 1'b0;
  logic scl_in, sda_in;
  logic scl_oe, sda_oe, ctl_srst, done, stuck;
  logic sda_stuck = 1'b0;
  int   release_after = 0;
  int   slave_pulses = 0;

  int n_tests = 0;
  int n_fail  = 0;

  int rises, bad_low, sda_len, gap_cnt, done_cnt, srst_at, oe_no_srst;
  bit seen_srst, srst_while_pend, stuck_at_done;

  always #10 clk = ~clk;

  assign scl_in = !scl_oe;
  assign sda_in = !(sda_oe || sda_stuck);

  always @(negedge scl_oe) begin
    slave_pulses = slave_pulses + 1;
    if (release_after > 0 && slave_pulses >= release_after) sda_stuck = 1'b0;
  end

  i2c_bus_unstick #(
    .CLK_PER_US(CPU), .HALF_US(HALF), .HOLD_US(HOLD), .GAP_US(GAP),
    .POLL_LIMIT(PLIM), .PULSE_LIMIT(ALIM), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .xfer_pending(xfer_pending),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .ctl_srst(ctl_srst), .done(done), .stuck(stuck)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    n_tests++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // Runs one recovery, sampling at falling edges. drop_at >= 0 clears
  // xfer_pending at that cycle; extra_req raises start_req mid-run.
  task automatic run_recovery(input int drop_at, input bit extra_req);
    bit p_scl = 1'b0;
    int run = 0;
    rises = 0; bad_low = 0; sda_len = 0; gap_cnt = 0; done_cnt = 0;
    srst_at = -1; oe_no_srst = 0; seen_srst = 0; srst_while_pend = 0;
    stuck_at_done = 0; slave_pulses = 0;
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      start_req = (extra_req && c == 30);
      if (c == drop_at) xfer_pending = 1'b0;
      if (scl_oe && !p_scl) begin rises++; run = 0; end
      if (scl_oe) run++;
      if (!scl_oe && p_scl && run != HALF) bad_low++;
      p_scl = scl_oe;
      if (sda_oe) sda_len++;
      if ((scl_oe || sda_oe) && !ctl_srst) oe_no_srst++;
      if (ctl_srst && !seen_srst) begin
        seen_srst = 1; srst_at = c;
        if (xfer_pending) srst_while_pend = 1;
      end
      if (seen_srst && !ctl_srst && !done) gap_cnt++;
      if (done) begin done_cnt++; stuck_at_done = stuck; break; end
    end
    start_req = 1'b0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (done) done_cnt++;
    end
  endtask

  task automatic t_reset;
    check("R1 scl_oe", scl_oe, 0);
    check("R1 sda_oe", sda_oe, 0);
    check("R1 ctl_srst", ctl_srst, 0);
    check("R1 done", done, 0);
    check("R1 stuck", stuck, 0);
  endtask

  task automatic t_clean_bus;
    run_recovery(-1, 0);
    check("R4 no pulses on idle bus", rises, 0);
    check("R7 start hold cycles", sda_len, HOLD*CPU);
    check("R3 reset release to done", gap_cnt, HOLD*CPU);
    check("R3 lines driven only in reset", oe_no_srst, 0);
    check("R8 single done", done_cnt, 1);
    check("R6 stuck clear", stuck_at_done, 0);
  endtask

  task automatic t_sda_stuck_short;
    sda_stuck = 1'b1; release_after = 3;
    run_recovery(-1, 1);
    check("R5 pulses until lines high", rises, 3);
    check("R5 pulse low width", bad_low, 0);
    check("R6 stuck clear after release", stuck_at_done, 0);
    check("R9 request while busy ignored", done_cnt, 1);
    release_after = 0;
  endtask

  task automatic t_sda_stuck_forever;
    sda_stuck = 1'b1; release_after = 0;
    run_recovery(-1, 0);
    check("R6 pulse count at limit", rises, ALIM);
    check("R6 stuck flag", stuck_at_done, 1);
    check("R7 start still issued", sda_len, HOLD*CPU);
    repeat (20) @(negedge clk);
    check("R8 stuck held while idle", stuck, 1);
    sda_stuck = 1'b0;
    run_recovery(-1, 0);
    check("R8 stuck cleared by new request", stuck_at_done, 0);
  endtask

  task automatic t_pending_drops;
    xfer_pending = 1'b1;
    run_recovery(6, 0);
    check("R2 no reset while pending", srst_while_pend, 0);
    check("R2 reset raised after drop", seen_srst, 1);
    check_range("R2 reset soon after drop", srst_at, 6, 6 + GAP*CPU + 2);
  endtask

  task automatic t_pending_stuck;
    xfer_pending = 1'b1;
    run_recovery(-1, 0);
    check("R2 proceeds despite pending", srst_while_pend, 1);
    check_range("R2 poll bound", srst_at, PLIM*GAP*CPU, PLIM*(GAP*CPU+1) + 3);
    check("R2 done reached", done_cnt, 1);
    xfer_pending = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_clean_bus();
    t_sda_stuck_short();
    t_sda_stuck_forever();
    t_pending_drops();
    t_pending_stuck();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule